// File: doc/BRIEF.md
# Level-2 Interrupt Aggregator with Per-Parent Routing

This block gathers level-sensitive interrupt sources into 32-bit words and drives several parent interrupt lines. The number of words is set by a parameter, from one to four. Each word has an enable register that software can write and a status view that shows the live source levels. A source reaches parent line p only if its enable bit is set and the routing mask for parent p and that word also has the bit set. One source can therefore reach any subset of the parents.

Nothing is acknowledged. A status bit follows its source, and a parent line stays high for as long as a routed and enabled source stays high. At reset each enable register is loaded with a forward mask, so chosen sources reach the parents without any write. While the suspend input is high, and wake support is built in, a fixed set of wake bits is ORed into each word's effective enable. The saved enable value is never changed by this, so it applies again alone as soon as suspend falls.

Top module: `l2irq_aggregator`

## Requirements
- R1: The byte address bits [4:3] select the word slot and bit [2] selects the register within it. A value of 0 in bit [2] selects the enable register and a value of 1 selects the status register. Word w therefore has its enable register at byte 8*w and its status register at byte 8*w+4.
- R2: A write to an enable register replaces the whole saved enable word, where a 1 unmasks a source and a 0 masks it. A read of that register returns the saved value.
- R3: A read of a status register returns the live source levels of that word. Read data is registered: it appears in the cycle after the read strobe and holds its value until the next read.
- R4: A write to a status register changes no enable register and no parent output.
- R5: Parent output p is set one cycle after any word w has a bit that is set in the source, the effective enable and the routing mask of p and w. Routing masks are packed parent-major: the mask for parent p and word w occupies bits [(p*NUM_WORDS+w)*32 +: 32] of ROUTE_MASK.
- R6: The default ROUTE_MASK is all ones, so that each parent sees every enabled source.
- R7: A synchronous active-high reset loads the enable register of word w with FWD_MASK[w*32 +: 32]. It also clears every parent output and the read data.
- R8: When WAKE_SUPPORT is 1 and suspend is high, the effective enable is the saved enable ORed with WAKE_MASK[w*32 +: 32]. An enable read still returns the saved value, and once suspend is low only the saved value applies again.
- R9: Slots at or above NUM_WORDS read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | NUM_WORDS*32 | Level interrupt sources, word w in bits [w*32 +: 32] |
| suspend | input | 1 | Selects the wake-extended effective enable |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Byte address bits [4:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| parent_irq | output | NUM_PARENTS | Registered parent interrupt lines |

## Verification
The assertions take the sources and the suspend input to be synchronous to clk and stable around its edge, so that the registered status and parent values can be compared with the values one cycle earlier. The bench meets this by changing every input only on the falling edge. It also keeps the read and write strobes to single-cycle pulses that are decoded in the same cycle. Source patterns are chosen so that each route, each wake bit and each masked bit changes a parent line in a way that can be seen.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;
    localparam int WORD_BITS = 32;
    localparam int MAX_WORDS = 4;
    localparam int SLOT_BITS = $clog2(MAX_WORDS);
    typedef logic [WORD_BITS-1:0] word_t;
    typedef logic [SLOT_BITS-1:0] slot_t;
endpackage

// File: rtl/l2irq_word.sv
module l2irq_word
    import l2irq_pkg::*;
#(
    parameter word_t FWD_INIT     = '0,
    parameter word_t WAKE_BITS    = '0,
    parameter bit    WAKE_SUPPORT = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wdata,
    input  logic  suspend,
    output word_t en_saved,
    output word_t en_eff
);
    word_t en_d, en_q;
    word_t wake_gate;

    always_comb begin
        en_d = en_q;
        if (wr_en) begin
            en_d = wdata;
        end
    end

    generate
        if (WAKE_SUPPORT) begin : g_wake
            assign wake_gate = {WORD_BITS{suspend}} & WAKE_BITS;
        end else begin : g_nowake
            logic unused_susp;
            assign unused_susp = suspend;
            assign wake_gate   = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= FWD_INIT;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_saved = en_q;
    assign en_eff   = en_q | wake_gate;
endmodule

// File: rtl/l2irq_router.sv
module l2irq_router
    import l2irq_pkg::*;
#(
    parameter int NUM_WORDS   = 2,
    parameter int NUM_PARENTS = 2,
    parameter logic [NUM_PARENTS*NUM_WORDS*WORD_BITS-1:0] ROUTE_MASK = '1
) (
    input  logic [NUM_WORDS*WORD_BITS-1:0] live,
    output logic [NUM_PARENTS-1:0]         hit
);
    genvar p;
    generate
        for (p = 0; p < NUM_PARENTS; p++) begin : g_par
            always_comb begin
                hit[p] = 1'b0;
                for (int w = 0; w < NUM_WORDS; w++) begin
                    hit[p] = hit[p] | (|(live[w*WORD_BITS +: WORD_BITS] &
                             ROUTE_MASK[(p*NUM_WORDS+w)*WORD_BITS +: WORD_BITS]));
                end
            end
        end
    endgenerate
endmodule

// File: rtl/l2irq_aggregator.sv
module l2irq_aggregator
    import l2irq_pkg::*;
#(
    parameter int NUM_WORDS   = 2,
    parameter int NUM_PARENTS = 2,
    parameter logic [NUM_WORDS*WORD_BITS-1:0] FWD_MASK  = '0,
    parameter logic [NUM_WORDS*WORD_BITS-1:0] WAKE_MASK = '0,
    parameter bit   WAKE_SUPPORT = 1'b1,
    parameter logic [NUM_PARENTS*NUM_WORDS*WORD_BITS-1:0] ROUTE_MASK = '1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_WORDS*WORD_BITS-1:0] src,
    input  logic                          suspend,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [SLOT_BITS+2:2]          bus_addr,
    input  logic [WORD_BITS-1:0]          bus_wdata,
    output logic [WORD_BITS-1:0]          bus_rdata,
    output logic [NUM_PARENTS-1:0]        parent_irq
);
    localparam int TOTAL_BITS = NUM_WORDS * WORD_BITS;

    typedef struct packed {
        logic [NUM_PARENTS-1:0] irq;
        word_t                  rdata;
    } state_t;

    state_t state_d, state_q;
    slot_t  slot;
    logic   sel_status;
    logic [NUM_WORDS-1:0]   word_wr;
    logic [TOTAL_BITS-1:0]  en_saved, en_eff, live;
    logic [NUM_PARENTS-1:0] hit;
    word_t  rd_word;

    assign slot       = bus_addr[SLOT_BITS+2:3];
    assign sel_status = bus_addr[2];

    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_word
            assign word_wr[w] = bus_wr && !sel_status && (slot == slot_t'(w));
            l2irq_word #(
                .FWD_INIT    (FWD_MASK[w*WORD_BITS +: WORD_BITS]),
                .WAKE_BITS   (WAKE_MASK[w*WORD_BITS +: WORD_BITS]),
                .WAKE_SUPPORT(WAKE_SUPPORT)
            ) word_i (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (word_wr[w]),
                .wdata   (bus_wdata),
                .suspend (suspend),
                .en_saved(en_saved[w*WORD_BITS +: WORD_BITS]),
                .en_eff  (en_eff[w*WORD_BITS +: WORD_BITS])
            );
        end
    endgenerate

    assign live = src & en_eff;

    l2irq_router #(
        .NUM_WORDS  (NUM_WORDS),
        .NUM_PARENTS(NUM_PARENTS),
        .ROUTE_MASK (ROUTE_MASK)
    ) router_i (
        .live(live),
        .hit (hit)
    );

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (slot == slot_t'(i)) begin
                rd_word = sel_status ? src[i*WORD_BITS +: WORD_BITS]
                                     : en_saved[i*WORD_BITS +: WORD_BITS];
            end
        end
    end

    always_comb begin
        state_d     = state_q;
        state_d.irq = hit;
        if (bus_rd) begin
            state_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign parent_irq = state_q.irq;
    assign bus_rdata  = state_q.rdata;
endmodule

// File: rtl/l2irq_checker.sv
module l2irq_checker
    import l2irq_pkg::*;
#(
    parameter int NUM_WORDS   = 2,
    parameter int NUM_PARENTS = 2
) (
    input logic                           clk,
    input logic                           rst,
    input logic [NUM_WORDS*WORD_BITS-1:0] src,
    input logic                           bus_rd,
    input logic [SLOT_BITS+2:2]           bus_addr,
    input logic [WORD_BITS-1:0]           bus_rdata,
    input logic [NUM_PARENTS-1:0]         parent_irq
);
    slot_t slot;
    logic  slot_ok;
    word_t src_sel;

    assign slot    = bus_addr[SLOT_BITS+2:3];
    assign slot_ok = (int'(slot) < NUM_WORDS);

    always_comb begin
        src_sel = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (slot == slot_t'(i)) src_sel = src[i*WORD_BITS +: WORD_BITS];
        end
    end

    AST_RESET_CLEARS_IRQ: assert property (@(posedge clk)
        rst |=> (parent_irq == '0)); // R7

    AST_NO_SRC_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |=> (parent_irq == '0)); // R5

    AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[2] && slot_ok) |=> (bus_rdata == $past(src_sel))); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R3

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !slot_ok) |=> (bus_rdata == '0)); // R9
endmodule

bind l2irq_aggregator l2irq_checker #(
    .NUM_WORDS  (NUM_WORDS),
    .NUM_PARENTS(NUM_PARENTS)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .src       (src),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .parent_irq(parent_irq)
);

// File: tb/l2irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module l2irq_aggregator_tb_top;
    localparam logic [63:0]  FWD   = {32'h0000_0F00, 32'h0000_000F};
    localparam logic [63:0]  WAKE  = {32'h0001_0000, 32'h8000_0000};
    localparam logic [127:0] ROUTE = {32'h0000_00FF, 32'hFFFF_0000,
                                      32'hFFFF_0000, 32'h0000_FFFF};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src = '0;
    logic        suspend = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:2]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, d_rdata;
    logic [1:0]  parent_irq;
    logic [0:0]  d_irq;

    always #2.5 clk = ~clk;

    l2irq_aggregator #(
        .NUM_WORDS(2), .NUM_PARENTS(2), .FWD_MASK(FWD),
        .WAKE_MASK(WAKE), .WAKE_SUPPORT(1'b1), .ROUTE_MASK(ROUTE)
    ) dut_i (
        .clk(clk), .rst(rst), .src(src), .suspend(suspend),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .parent_irq(parent_irq)
    );

    l2irq_aggregator #(.NUM_WORDS(1), .NUM_PARENTS(1)) dflt_i (
        .clk(clk), .rst(rst), .src(src[31:0]), .suspend(suspend),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(d_rdata), .parent_irq(d_irq)
    );

    int checks = 0, failures = 0;
    bit started = 0, done = 0;
    string phase = "R7";

    logic [31:0] m_en [2];
    logic [31:0] d_en;
    logic [1:0]  exp_irq;
    logic        exp_d_irq;
    logic [31:0] exp_rdata, exp_d_rdata;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_en[0] = FWD[31:0]; m_en[1] = FWD[63:32]; d_en = '0;
            exp_irq = '0; exp_d_irq = 1'b0; exp_rdata = '0; exp_d_rdata = '0;
        end else begin
            int s;
            s = int'(bus_addr[4:3]);
            exp_irq = '0;
            for (int p = 0; p < 2; p++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] eff;
                    eff = m_en[w] | (suspend ? WAKE[w*32 +: 32] : 32'h0);
                    if ((src[w*32 +: 32] & eff & ROUTE[(p*2+w)*32 +: 32]) != 0)
                        exp_irq[p] = 1'b1;
                end
            end
            exp_d_irq = ((src[31:0] & d_en) != 0);
            if (bus_rd) begin
                if (s < 2) exp_rdata = bus_addr[2] ? src[s*32 +: 32] : m_en[s];
                else       exp_rdata = '0;
                if (s == 0) exp_d_rdata = bus_addr[2] ? src[31:0] : d_en;
                else        exp_d_rdata = '0;
            end
            if (bus_wr && !bus_addr[2]) begin
                if (s < 2)  m_en[s] = bus_wdata;
                if (s == 0) d_en = bus_wdata;
            end
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            check({phase, " parent_irq"}, {30'h0, parent_irq}, {30'h0, exp_irq});
            check({phase, " rdata"}, bus_rdata, exp_rdata);
            check({phase, " R6 dflt irq"}, {31'h0, d_irq}, {31'h0, exp_d_irq});
            check({phase, " dflt rdata"}, d_rdata, exp_d_rdata);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_addr = a[4:2]; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a);
        bus_addr = a[4:2]; bus_rd = 1'b1;
        step(1);
        bus_rd = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        check("R7 reset irq", {30'h0, parent_irq}, 32'h0);
        check("R7 reset rdata", bus_rdata, 32'h0);
        phase = "R7";
        rd(5'h00); check("R7 fwd word0", bus_rdata, 32'h0000_000F);
        phase = "R1";
        rd(5'h08); check("R1 R7 fwd word1", bus_rdata, 32'h0000_0F00);
        phase = "R9";
        rd(5'h10); check("R9 unused slot2", bus_rdata, 32'h0);
        wr(5'h18, 32'hDEAD_BEEF);
        rd(5'h18); check("R9 unused slot3 after write", bus_rdata, 32'h0);
        phase = "R2";
        wr(5'h00, 32'h0000_0101);
        rd(5'h00); check("R2 enable readback", bus_rdata, 32'h0000_0101);
        phase = "R5";
        src[31:0] = 32'h0000_0001; step(2);
        check("R5 p0 via word0", {30'h0, parent_irq}, 32'h1);
        src[31:0] = '0; src[63:32] = 32'h0000_0010; step(2);
        check("R5 masked word1 bit", {30'h0, parent_irq}, 32'h0);
        wr(5'h08, 32'h0000_0010); step(1);
        check("R5 p1 via word1 parent-major", {30'h0, parent_irq}, 32'h2);
        src[63:32] = 32'h0001_0010; src[31:0] = 32'h0000_0100; step(2);
        check("R5 both parents", {30'h0, parent_irq}, 32'h3);
        phase = "R4";
        wr(5'h04, 32'hFFFF_FFFF); step(1);
        rd(5'h00); check("R4 status write ignored", bus_rdata, 32'h0000_0101);
        check("R4 irq unchanged", {30'h0, parent_irq}, 32'h3);
        phase = "R3";
        src[31:0] = 32'hA5A5_0001;
        rd(5'h04); check("R3 status live word0", bus_rdata, 32'hA5A5_0001);
        src[31:0] = 32'h0000_0002; step(2);
        check("R3 rdata held", bus_rdata, 32'hA5A5_0001);
        rd(5'h0C); check("R3 status live word1", bus_rdata, 32'h0001_0010);
        phase = "R8";
        wr(5'h00, 32'h0); wr(5'h08, 32'h0);
        src = {32'h0001_0000, 32'h8000_0000}; step(2);
        check("R8 awake no irq", {30'h0, parent_irq}, 32'h0);
        suspend = 1'b1; step(2);
        check("R8 wake bits route", {30'h0, parent_irq}, 32'h3);
        rd(5'h00); check("R8 saved enable kept", bus_rdata, 32'h0);
        suspend = 1'b0; step(2);
        check("R8 resume saved only", {30'h0, parent_irq}, 32'h0);
        phase = "R6";
        src = 64'h0000_0000_4000_0000;
        wr(5'h00, 32'h4000_0000); step(1);
        check("R6 dflt route all ones", {31'h0, d_irq}, 32'h1);
        check("R5 word0 bit30 only p1", {30'h0, parent_irq}, 32'h2);
        phase = "R7";
        rst = 1'b1; step(1); rst = 1'b0;
        check("R7 sync reset irq", {30'h0, parent_irq}, 32'h0);
        rd(5'h00); check("R7 fwd reloaded", bus_rdata, 32'h0000_000F);
        step(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule